// File: doc/BRIEF.md
# Multi-Mode Reload Timer Channel

One timer channel built around a single 16-bit counter and a 16-bit reload value. A 2-bit mode field selects one of four uses of that counter. It can be a periodic timer driven by a prescaled clock enable, optionally gated by an external pin. It can be an event counter that counts either up or down on a selectable event. It can be a retriggerable-when-idle one-shot pulse generator. It can be a continuous PWM generator. Every wrap of the counter produces a one-cycle strobe, which a neighbouring channel can use as a chained event. The wrap also sets a sticky interrupt request.

Software programs the channel through a byte-wide write port. Address 0 holds the mode byte: bits [1:0] mode (00 timer, 01 event, 10 one-shot, 11 PWM), bit 2 gate enable, bit 3 pin inversion, bit 4 toggle-output enable, bits [7:6] clock select. Address 1 is the control byte: bit 0 run, bit 1 count up, bits [3:2] event select, and bit 4 clears the interrupt when written as 1. Addresses 2 and 3 hold the low and high bytes of the reload value. The prescaler and the other channels are outside the block. Their outputs arrive as single-cycle enable and strobe inputs.

Top module: `mm_reload_timer`

## Requirements
- R1: After reset, out_o, ovf_o and irq_o are 0.
- R2: The counter only moves while the run bit is 1. Setting run from 0 to 1 loads the counter. With run at 0 no strobe occurs.
- R3: In timer mode (00), the count source is ce_i[clock select]. A strobe occurs every reload+1 ticks of that source.
- R4: With gate enable (mode bit 2) set in timer mode, ticks count only while the conditioned pin level is 1.
- R5: In event mode (01), event select picks the count source. 00 is a rising edge of the conditioned pin, 01 is b2_ovf_i, 10 is lo_ovf_i and 11 is hi_ovf_i.
- R6: The up bit takes effect only in event mode. Counting up from reload, the strobe period is 65536-reload events. All other modes count down.
- R7: ovf_o is high for exactly one cycle per wrap. irq_o goes high with the strobe and stays high until written clear.
- R8: With toggle enable (mode bit 4) in timer or event mode, out_o inverts on each wrap. Starting the channel resets it to 0.
- R9: In one-shot mode (10), a selected event while running drives out_o high for reload+1 ticks, then out_o falls and one strobe occurs. Events during the pulse, or while stopped, are ignored.
- R10: In PWM mode (11), the frame is 256 clock-select ticks. out_o is high for reload[7:0] ticks of each frame, and there is one strobe per frame.
- R11: Mode bit 3 inverts the external pin before it is used as a gate level or an edge source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| ce_i | input | 4 | Prescaled clock enables, picked by clock select |
| ext_i | input | 1 | External pin |
| b2_ovf_i | input | 1 | Wrap strobe of the designated remote timer |
| lo_ovf_i | input | 1 | Wrap strobe of the lower neighbour |
| hi_ovf_i | input | 1 | Wrap strobe of the higher neighbour |
| out_o | output | 1 | Pulse, PWM or toggle output |
| ovf_o | output | 1 | One-cycle wrap strobe |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
Any counter value that is off by one shows up as a wrong number of strobes in a fixed window. Each window is sized to hold tens of periods, so even a single extra or missing tick is visible within one period. A wrong source-select or gate state shows up immediately as zero strobes, or as the wrong rate, in a window. A stuck one-shot or PWM state shows up in the number of high cycles on out_o. That count is observed over one pulse, or over exactly two PWM frames.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  typedef enum logic [1:0] {
    MD_TIMER   = 2'b00,
    MD_EVENT   = 2'b01,
    MD_ONESHOT = 2'b10,
    MD_PWM     = 2'b11
  } mode_e;

  localparam int A_MODE = 0;
  localparam int A_CTRL = 1;
  localparam int A_RLD0 = 2;

  typedef struct packed {
    mode_e      mode;
    logic       gate_en;
    logic       in_inv;
    logic       tog_en;
    logic [1:0] clk_sel;
    logic       start;
    logic       up;
    logic [1:0] trig_sel;
  } cfg_t;
endpackage

// File: rtl/mmt_regs.sv
module mmt_regs
  import mmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output cfg_t              cfg_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              start_rise_o,
  output logic              irq_clr_o
);
  localparam int NB = CNT_W / 8;

  cfg_t             cfg_q;
  logic [CNT_W-1:0] reload_q;
  logic             wr_mode, wr_ctrl;

  assign wr_mode = wr_en_i && (wr_addr_i == ADDR_W'(A_MODE));
  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      if (wr_mode) begin
        cfg_q.mode    <= mode_e'(wr_data_i[1:0]);
        cfg_q.gate_en <= wr_data_i[2];
        cfg_q.in_inv  <= wr_data_i[3];
        cfg_q.tog_en  <= wr_data_i[4];
        cfg_q.clk_sel <= wr_data_i[7:6];
      end
      if (wr_ctrl) begin
        cfg_q.start    <= wr_data_i[0];
        cfg_q.up       <= wr_data_i[1];
        cfg_q.trig_sel <= wr_data_i[3:2];
      end
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_rld_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) reload_q[8*k +: 8] <= '0;
      else if (wr_en_i && (wr_addr_i == ADDR_W'(A_RLD0 + k))) reload_q[8*k +: 8] <= wr_data_i;
    end
  end

  assign cfg_o        = cfg_q;
  assign reload_o     = reload_q;
  assign start_rise_o = wr_ctrl && wr_data_i[0] && !cfg_q.start;
  assign irq_clr_o    = wr_ctrl && wr_data_i[4];

  AST_START_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rise_o |=> cfg_o.start); // R2
endmodule

// File: rtl/mmt_src.sv
module mmt_src #(
  parameter int N_CE = 4,
  localparam int SEL_W = $clog2(N_CE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CE-1:0]  ce_i,
  input  logic             ext_i,
  input  logic             b2_ovf_i,
  input  logic             lo_ovf_i,
  input  logic             hi_ovf_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             in_inv_i,
  output logic             base_tick_o,
  output logic             event_o,
  output logic             gate_lvl_o
);
  logic ext_q, ext_qq, ext_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q  <= 1'b0;
      ext_qq <= 1'b0;
    end else begin
      ext_q  <= ext_i ^ in_inv_i;
      ext_qq <= ext_q;
    end
  end

  assign ext_rise    = ext_q & ~ext_qq;
  assign gate_lvl_o  = ext_q;
  assign base_tick_o = ce_i[clk_sel_i];

  always_comb begin
    case (trig_sel_i)
      2'b00:   event_o = ext_rise;
      2'b01:   event_o = b2_ovf_i;
      2'b10:   event_o = lo_ovf_i;
      default: event_o = hi_ovf_i;
    endcase
  end

  AST_PIN_EDGE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_sel_i == 2'b00 && event_o && $stable(trig_sel_i) && $stable(in_inv_i))
      |=> !(event_o && trig_sel_i == 2'b00)); // R5
endmodule

// File: rtl/mmt_core.sv
module mmt_core
  import mmt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PWM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic             gate_en_i,
  input  logic             tog_en_i,
  input  logic             start_i,
  input  logic             up_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             start_rise_i,
  input  logic             irq_clr_i,
  input  logic             base_tick_i,
  input  logic             event_i,
  input  logic             gate_lvl_i,
  output logic             out_o,
  output logic             ovf_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] PWM_TOP = CNT_W'((64'd1 << PWM_W) - 64'd1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, top_val;
  logic active_q, tog_q, ovf_q, irq_q;
  logic tick, dir_up, at_end, trig, wrap_evt, pwm_hi;

  always_comb begin
    tick   = 1'b0;
    dir_up = 1'b0;
    case (mode_i)
      MD_TIMER:   tick = base_tick_i & (~gate_en_i | gate_lvl_i);
      MD_EVENT: begin
        tick   = event_i;
        dir_up = up_i;
      end
      MD_ONESHOT: tick = base_tick_i & active_q;
      default:    tick = base_tick_i;
    endcase
    top_val  = (mode_i == MD_PWM) ? PWM_TOP : reload_i;
    at_end   = dir_up ? (cnt_q == CNT_MAX) : (cnt_q == '0);
    trig     = (mode_i == MD_ONESHOT) & start_i & event_i & ~active_q & ~start_rise_i;
    wrap_evt = start_i & ~start_rise_i & ~trig & tick & at_end;
    pwm_hi   = start_i & (mode_i == MD_PWM) & (cnt_q[PWM_W-1:0] < reload_i[PWM_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      tog_q    <= 1'b0;
      ovf_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      ovf_q <= wrap_evt;
      irq_q <= wrap_evt | (irq_q & ~irq_clr_i);
      if (start_rise_i) begin
        cnt_q    <= top_val;
        tog_q    <= 1'b0;
        active_q <= 1'b0;
      end else if (!start_i) begin
        active_q <= 1'b0;
      end else if (trig) begin
        cnt_q    <= reload_i;
        active_q <= 1'b1;
      end else if (tick) begin
        if (at_end) begin
          tog_q <= ~tog_q;
          if (mode_i == MD_ONESHOT) active_q <= 1'b0;
          else                      cnt_q    <= top_val;
        end else begin
          cnt_q <= dir_up ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    case (mode_i)
      MD_ONESHOT: out_o = active_q;
      MD_PWM:     out_o = pwm_hi;
      default:    out_o = tog_en_i & tog_q;
    endcase
  end

  assign ovf_o = ovf_q;
  assign irq_o = irq_q;

  AST_NO_STROBE_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !ovf_o); // R2
  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !start_rise_i) |=> $stable(cnt_q)); // R2
  AST_IRQ_WITH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> irq_o); // R7
  AST_DOWN_OUTSIDE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == MD_TIMER && tick && cnt_q != '0)
      |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R6
  AST_TOGGLE_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> tog_q != $past(tog_q)); // R8
  AST_PULSE_END_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(active_q) && start_i && mode_i == MD_ONESHOT) |-> ovf_o); // R9
endmodule

// File: rtl/mm_reload_timer.sv
module mm_reload_timer
  import mmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PWM_W  = 8,
  parameter int N_CE   = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [N_CE-1:0]   ce_i,
  input  logic              ext_i,
  input  logic              b2_ovf_i,
  input  logic              lo_ovf_i,
  input  logic              hi_ovf_i,
  output logic              out_o,
  output logic              ovf_o,
  output logic              irq_o
);
  localparam int SEL_W = $clog2(N_CE);

  cfg_t             cfg;
  logic [CNT_W-1:0] reload;
  logic             start_rise, irq_clr, base_tick, evt, gate_lvl;

  mmt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .cfg_o(cfg), .reload_o(reload), .start_rise_o(start_rise), .irq_clr_o(irq_clr)
  );

  mmt_src #(.N_CE(N_CE)) i_src (
    .clk_i, .rst_ni, .ce_i, .ext_i, .b2_ovf_i, .lo_ovf_i, .hi_ovf_i,
    .clk_sel_i(SEL_W'(cfg.clk_sel)), .trig_sel_i(cfg.trig_sel), .in_inv_i(cfg.in_inv),
    .base_tick_o(base_tick), .event_o(evt), .gate_lvl_o(gate_lvl)
  );

  mmt_core #(.CNT_W(CNT_W), .PWM_W(PWM_W)) i_core (
    .clk_i, .rst_ni,
    .mode_i(cfg.mode), .gate_en_i(cfg.gate_en), .tog_en_i(cfg.tog_en),
    .start_i(cfg.start), .up_i(cfg.up), .reload_i(reload),
    .start_rise_i(start_rise), .irq_clr_i(irq_clr),
    .base_tick_i(base_tick), .event_i(evt), .gate_lvl_i(gate_lvl),
    .out_o, .ovf_o, .irq_o
  );
endmodule

// File: tb/test_mm_reload_timer.sv
`timescale 1ns/1ps
module test_mm_reload_timer;
  localparam time TCK = 4ns;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] ce;
  logic       ext = 1'b0, b2, lo, hi;
  logic       out, ovf, irq;
  logic [7:0] div = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(TCK/2) clk = ~clk;
  always @(negedge clk) div <= div + 8'd1;
  assign ce[0] = 1'b1;
  assign ce[1] = div[0] == 1'b0;
  assign ce[2] = div[1:0] == 2'b0;
  assign ce[3] = div[2:0] == 3'b0;
  assign lo = ce[1];
  assign hi = ce[2];
  assign b2 = ce[3];

  mm_reload_timer i_mm_reload_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ce_i(ce), .ext_i(ext), .b2_ovf_i(b2), .lo_ovf_i(lo), .hi_ovf_i(hi),
    .out_o(out), .ovf_o(ovf), .irq_o(irq)
  );

  // {mode, sel, up, reload, cycles}; sel is clock select in timer mode, event select in event mode
  localparam int NV = 8;
  localparam logic [32:0] VEC [NV] = '{
    {2'b00, 2'd0, 1'b0, 16'd9,      12'd200},
    {2'b00, 2'd1, 1'b0, 16'd4,      12'd400},
    {2'b00, 2'd2, 1'b0, 16'd2,      12'd480},
    {2'b00, 2'd3, 1'b1, 16'd1,      12'd800},
    {2'b01, 2'd1, 1'b0, 16'd3,      12'd320},
    {2'b01, 2'd2, 1'b1, 16'hFFF0,   12'd320},
    {2'b01, 2'd3, 1'b0, 16'd0,      12'd64},
    {2'b01, 2'd2, 1'b1, 16'hFFFF,   12'd64}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [1:0] md, input logic [1:0] csel, input logic gate,
                       input logic inv, input logic tog, input logic up,
                       input logic [1:0] tsel, input logic [15:0] rld);
    wr(3'd1, 8'h00);
    wr(3'd0, {csel, 1'b0, tog, inv, gate, md});
    wr(3'd2, rld[7:0]);
    wr(3'd3, rld[15:8]);
    wr(3'd1, {4'b0, tsel, up, 1'b1});
  endtask

  task automatic run(input int n, output int n_ovf, output int n_hi, output int n_tog, output int n_dbl);
    logic p_out = out, p_ovf = 1'b0;
    n_ovf = 0; n_hi = 0; n_tog = 0; n_dbl = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      n_ovf += int'(ovf);
      n_hi  += int'(out);
      n_tog += int'(out != p_out);
      n_dbl += int'(ovf && p_ovf);
      p_out = out; p_ovf = ovf;
    end
  endtask

  initial begin
    #(TCK * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int o, h, t, d;
    repeat (3) @(negedge clk);
    check("R1 out", int'(out), 0);
    check("R1 ovf", int'(ovf), 0);
    check("R1 irq", int'(irq), 0);
    rst_n = 1'b1;

    // table: strobe count over a window, R3/R5/R6
    for (int v = 0; v < NV; v++) begin
      logic [1:0] md; logic [1:0] sel; logic up; logic [15:0] rld; int n, div_n, ticks, per;
      {md, sel, up, rld, n} = {VEC[v][32:12], 20'd0} >> 20 | 33'(VEC[v][11:0]);
      md = VEC[v][32:31]; sel = VEC[v][30:29]; up = VEC[v][28]; rld = VEC[v][27:12]; n = int'(VEC[v][11:0]);
      if (md == 2'b00) div_n = 1 << sel;
      else div_n = (sel == 2'd1) ? 8 : (sel == 2'd2) ? 2 : 4;
      ticks = n / div_n;
      per = (md == 2'b01 && up) ? 65536 - int'(rld) : int'(rld) + 1;
      if (md == 2'b00) setup(md, sel, 0, 0, 0, up, 2'd0, rld);
      else setup(md, 2'd0, 0, 0, 0, up, sel, rld);
      run(n, o, h, t, d);
      check(md == 2'b00 ? "R3/R6 timer strobes" : "R5/R6 event strobes", o, ticks / per);
    end

    // R2 stopped: no strobes, R7 single-cycle strobe and sticky irq
    setup(2'b00, 2'd0, 0, 0, 0, 0, 2'd0, 16'd3);
    run(40, o, h, t, d);
    check("R7 strobe count", o, 10);
    check("R7 strobe width", d, 0);
    check("R7 irq set", int'(irq), 1);
    wr(3'd1, 8'h00);
    wr(3'd1, 8'h10);
    check("R7 irq cleared", int'(irq), 0);
    run(20, o, h, t, d);
    check("R2 no strobe when stopped", o, 0);
    check("R2 irq stays clear", int'(irq), 0);

    // R4 gate, R11 inversion
    ext = 1'b1;
    setup(2'b00, 2'd0, 1, 0, 0, 0, 2'd0, 16'd1);
    run(40, o, h, t, d);
    check("R4 gate open", o, 20);
    ext = 1'b0;
    repeat (4) @(negedge clk);
    run(40, o, h, t, d);
    check("R4 gate closed", o, 0);
    wr(3'd0, 8'b0000_1100);
    repeat (4) @(negedge clk);
    run(40, o, h, t, d);
    check("R11 inverted pin opens gate", o, 20);

    // R5 pin edges in event mode: 8 rising edges, reload 3
    setup(2'b01, 2'd0, 0, 0, 0, 0, 2'd0, 16'd3);
    o = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      o += int'(ovf);
      ext = (i % 4) < 2;
    end
    ext = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      o += int'(ovf);
    end
    check("R5 pin edge events", o, 2);

    // R8 toggle output
    setup(2'b00, 2'd0, 0, 0, 1, 0, 2'd0, 16'd4);
    run(50, o, h, t, d);
    check("R8 toggles", t, 10);

    // R9 one-shot with ignored retrigger
    ext = 1'b0;
    setup(2'b10, 2'd0, 0, 0, 0, 0, 2'd0, 16'd5);
    h = 0; o = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      h += int'(out); o += int'(ovf);
      if (i == 0) ext = 1'b1;
      if (i == 3) ext = 1'b0;
      if (i == 4) ext = 1'b1;
      if (i == 6) ext = 1'b0;
    end
    check("R9 pulse width", h, 6);
    check("R9 end strobe", o, 1);
    wr(3'd1, 8'h00);
    h = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      h += int'(out);
      ext = (i > 1 && i < 5);
    end
    check("R9 stopped ignores trigger", h, 0);

    // R10 PWM
    setup(2'b11, 2'd0, 0, 0, 0, 0, 2'd0, 16'd64);
    run(512, o, h, t, d);
    check("R10 pwm high cycles", h, 128);
    check("R10 pwm frames", o, 2);
    wr(3'd2, 8'd0);
    run(256, o, h, t, d);
    check("R10 zero width", h, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule